// File: doc/BRIEF.md
# Serial BCD Digit Adder

This block adds decimal numbers one digit per step. On each step it takes two 4-bit digits, one from a memory-side register and one from a working-side register. It adds them together with a stored carry bit. It returns a corrected decimal digit and a carry-out. The carry-out is captured in a carry flip-flop when the step strobe is accepted, so it becomes the carry-in of the next, more significant digit. The sequencer drives the digits from least to most significant.

The working-side digit can be passed through unchanged or replaced by its nines complement. Subtraction therefore uses the same path: the control logic presets the carry flip-flop to one before the lowest digit and selects the complement form. Combinational status flags tell the sequencer whether the uncorrected sum was zero or ten, or exactly nine. An error output flags any operand code outside the decimal range.

Top module: `bcd_serial_digit_adder`

## Requirements
- R1: Digits use 4-bit 8-4-2-1 codes with valid values 0 to 9. For valid inputs, `sum_digit` shows (mem + operand + carry_q) mod 10 combinationally, and is never above 9.
- R2: `carry_out` is high exactly when mem + operand + carry_q is greater than 9, for sums up to 19.
- R3: With `comp_sel` = 0 the operand is `work_digit`. With `comp_sel` = 1 the operand is 9 − `work_digit`.
- R4: A rising clock edge with `step` high, both control inputs low and no error loads `carry_out` into `carry_q`. With `step` low and both control inputs low, `carry_q` keeps its value.
- R5: `carry_clr` forces `carry_q` to 0 at the next edge. It overrides `carry_set` and `step`.
- R6: `carry_set` without `carry_clr` forces `carry_q` to 1 at the next edge and overrides `step`. After this preset, a run of complemented steps gives A − B in ten's complement, with a final carry of 1 when A ≥ B.
- R7: `sum_zero` is high when the uncorrected sum equals 0 or 10. `sum_nonzero` is always its inverse.
- R8: `sum_nine` is high exactly when the uncorrected sum equals 9.
- R9: `digit_err` is high when either input digit is above 9. A step taken while it is high leaves `carry_q` unchanged.
- R10: With `rst_n` low, `carry_q` is 0 and stays 0 until released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Digit step strobe; captures the carry |
| carry_clr | input | 1 | Synchronous carry clear |
| carry_set | input | 1 | Synchronous carry preset |
| comp_sel | input | 1 | 1 selects nines complement of the working digit |
| mem_digit | input | 4 | Memory-side digit |
| work_digit | input | 4 | Working-side digit |
| sum_digit | output | 4 | Corrected decimal digit |
| carry_out | output | 1 | Decimal carry of the present step |
| carry_q | output | 1 | Stored carry, used as carry-in |
| sum_zero | output | 1 | Uncorrected sum is 0 or 10 |
| sum_nonzero | output | 1 | Inverse of sum_zero |
| sum_nine | output | 1 | Uncorrected sum is 9 |
| digit_err | output | 1 | An input digit is above 9 |

## Verification
The carry flip-flop can receive a step capture and a clear or preset request in the same cycle. The bench provokes this by raising `step` together with `carry_clr` or `carry_set`, using digits whose carry-out is the opposite of what the control input forces. It then reads `carry_q` after the edge, so the winning source can be told from the losing one. A step that arrives with an out-of-range digit is also provoked. It is judged by whether the previously preset carry survives.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;
  localparam int DW = 4;
  localparam int SW = DW + 1;
  localparam logic [DW-1:0] DMAX = 4'd9;

  typedef logic [DW-1:0] digit_t;
  typedef logic [SW-1:0] raw_t;

  typedef struct packed {
    logic   cy;
    digit_t dig;
  } corr_t;

  function automatic logic digit_ok(digit_t d);
    return d <= DMAX;
  endfunction

  function automatic digit_t nines_of(digit_t d);
    return DMAX - d;
  endfunction

  function automatic corr_t correct(raw_t r);
    corr_t c;
    if (r > raw_t'(DMAX)) begin
      c.cy  = 1'b1;
      c.dig = digit_t'(r - raw_t'(DMAX) - raw_t'(1));
    end else begin
      c.cy  = 1'b0;
      c.dig = digit_t'(r);
    end
    return c;
  endfunction

  function automatic logic zero_or_ten(raw_t r);
    return (r == raw_t'(0)) || (r == raw_t'(DMAX) + raw_t'(1));
  endfunction

  function automatic logic is_nine(raw_t r);
    return r == raw_t'(DMAX);
  endfunction
endpackage

// File: rtl/bcd_operand_prep.sv
module bcd_operand_prep
  import bcd_add_pkg::*;
(
  input  digit_t mem_d,
  input  digit_t work_d,
  input  logic   comp,
  output digit_t a_op,
  output digit_t b_op,
  output logic   bad
);
  always_comb begin
    a_op = mem_d;
    b_op = comp ? nines_of(work_d) : work_d;
    bad  = !(digit_ok(mem_d) && digit_ok(work_d));
  end
endmodule

// File: rtl/bcd_ripple_adder.sv
module bcd_ripple_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W:0]   raw
);
  logic [W:0] cy;
  assign cy[0] = cin;
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign raw[i]  = a[i] ^ b[i] ^ cy[i];
    assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
  end
  assign raw[W] = cy[W];
endmodule

// File: rtl/bcd_dec_corrector.sv
module bcd_dec_corrector
  import bcd_add_pkg::*;
(
  input  raw_t   raw,
  output digit_t dig,
  output logic   cy_out,
  output logic   zero,
  output logic   nonzero,
  output logic   nine
);
  corr_t c;
  always_comb begin
    c       = correct(raw);
    dig     = c.dig;
    cy_out  = c.cy;
    zero    = zero_or_ten(raw);
    nonzero = ~zero;
    nine    = is_nine(raw);
  end
endmodule

// File: rtl/bcd_carry_reg.sv
module bcd_carry_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic clr,
  input  logic set,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (clr)  q <= 1'b0;
    else if (set)  q <= 1'b1;
    else if (take) q <= d;
  end
endmodule

// File: rtl/bcd_serial_digit_adder.sv
module bcd_serial_digit_adder
  import bcd_add_pkg::*;
#(
  parameter int DIGIT_W = bcd_add_pkg::DW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic               carry_clr,
  input  logic               carry_set,
  input  logic               comp_sel,
  input  logic [DIGIT_W-1:0] mem_digit,
  input  logic [DIGIT_W-1:0] work_digit,
  output logic [DIGIT_W-1:0] sum_digit,
  output logic               carry_out,
  output logic               carry_q,
  output logic               sum_zero,
  output logic               sum_nonzero,
  output logic               sum_nine,
  output logic               digit_err
);
  localparam int RAW_W = DIGIT_W + 1;

  digit_t           op_a, op_b;
  logic [RAW_W-1:0] raw_sum;
  logic             step_take;

  bcd_operand_prep u_prep (
    .mem_d (mem_digit),
    .work_d(work_digit),
    .comp  (comp_sel),
    .a_op  (op_a),
    .b_op  (op_b),
    .bad   (digit_err)
  );

  bcd_ripple_adder #(.W(DIGIT_W)) u_add (
    .a  (op_a),
    .b  (op_b),
    .cin(carry_q),
    .raw(raw_sum)
  );

  bcd_dec_corrector u_corr (
    .raw    (raw_sum),
    .dig    (sum_digit),
    .cy_out (carry_out),
    .zero   (sum_zero),
    .nonzero(sum_nonzero),
    .nine   (sum_nine)
  );

  assign step_take = step & ~digit_err;

  bcd_carry_reg u_cy (
    .clk  (clk),
    .rst_n(rst_n),
    .take (step_take),
    .clr  (carry_clr),
    .set  (carry_set),
    .d    (carry_out),
    .q    (carry_q)
  );
endmodule

// File: rtl/bcd_adder_chk.sv
module bcd_adder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       step,
  input logic       carry_clr,
  input logic       carry_set,
  input logic       digit_err,
  input logic       carry_out,
  input logic       carry_q,
  input logic       sum_zero,
  input logic       sum_nonzero,
  input logic       sum_nine,
  input logic [3:0] sum_digit,
  input logic [4:0] raw_sum
);
  // R5
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_clr |=> !carry_q);
  // R6
  set_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_set && !carry_clr |=> carry_q);
  // R4
  step_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && !carry_clr && !carry_set && !digit_err |=> carry_q == $past(carry_out));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !carry_clr && !carry_set |=> $stable(carry_q));
  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && digit_err && !carry_clr && !carry_set |=> $stable(carry_q));
  // R7
  flag_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_zero != sum_nonzero);
  // R8
  nine_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !digit_err && sum_nine |-> sum_digit == 4'd9 && !carry_out);
  // R1
  digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !digit_err |-> sum_digit <= 4'd9);
  // R2
  carry_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !digit_err |-> carry_out == (raw_sum > 5'd9));
endmodule

bind bcd_serial_digit_adder bcd_adder_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .step       (step),
  .carry_clr  (carry_clr),
  .carry_set  (carry_set),
  .digit_err  (digit_err),
  .carry_out  (carry_out),
  .carry_q    (carry_q),
  .sum_zero   (sum_zero),
  .sum_nonzero(sum_nonzero),
  .sum_nine   (sum_nine),
  .sum_digit  (sum_digit),
  .raw_sum    (raw_sum)
);

// File: tb/tb_bcd_serial_digit_adder.sv
module tb_bcd_serial_digit_adder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 1'b0, carry_clr = 1'b0, carry_set = 1'b0, comp_sel = 1'b0;
  logic [3:0] mem_digit = 4'd0, work_digit = 4'd0;
  logic [3:0] sum_digit;
  logic carry_out, carry_q, sum_zero, sum_nonzero, sum_nine, digit_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_serial_digit_adder dut (
    .clk(clk), .rst_n(rst_n), .step(step), .carry_clr(carry_clr),
    .carry_set(carry_set), .comp_sel(comp_sel), .mem_digit(mem_digit),
    .work_digit(work_digit), .sum_digit(sum_digit), .carry_out(carry_out),
    .carry_q(carry_q), .sum_zero(sum_zero), .sum_nonzero(sum_nonzero),
    .sum_nine(sum_nine), .digit_err(digit_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic preset(input bit c);
    @(negedge clk);
    step = 1'b0; carry_clr = !c; carry_set = c;
    @(negedge clk);
    carry_clr = 1'b0; carry_set = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk(carry_q == 1'b0, "R10 carry in reset", carry_q, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(carry_q == 1'b0, "R10 carry after release", carry_q, 0);
    chk(sum_zero == 1'b1, "R7 zero flag at 0+0", sum_zero, 1);

    // exhaustive sweep: every code pair, both forms, both carry-ins
    for (int c = 0; c < 2; c++) begin
      for (int cp = 0; cp < 2; cp++) begin
        for (int m = 0; m < 16; m++) begin
          for (int w = 0; w < 16; w++) begin
            int op, tot;
            bit bad;
            preset(c[0]);
            @(negedge clk);
            mem_digit = m[3:0]; work_digit = w[3:0]; comp_sel = cp[0]; step = 1'b1;
            #1;
            bad = (m > 9) || (w > 9);
            op  = cp ? 9 - w : w;
            tot = m + op + c;
            chk(digit_err == bad, "R9 error flag", digit_err, bad);
            if (!bad) begin
              chk(sum_digit == 4'(tot % 10), "R1 R3 sum digit", sum_digit, tot % 10);
              chk(carry_out == (tot > 9), "R2 carry out", carry_out, tot > 9);
              chk(sum_zero == (tot == 0 || tot == 10), "R7 zero flag", sum_zero, tot == 0 || tot == 10);
              chk(sum_nonzero == !(tot == 0 || tot == 10), "R7 nonzero flag", sum_nonzero, !(tot == 0 || tot == 10));
              chk(sum_nine == (tot == 9), "R8 nine flag", sum_nine, tot == 9);
            end
            @(negedge clk);
            step = 1'b0;
            if (bad) chk(carry_q == c[0], "R9 carry kept on bad step", carry_q, c);
            else     chk(carry_q == (tot > 9), "R4 carry captured", carry_q, tot > 9);
          end
        end
      end
    end

    // R4: no step, carry holds
    preset(1'b0);
    @(negedge clk);
    mem_digit = 4'd9; work_digit = 4'd9; comp_sel = 1'b0; step = 1'b0;
    @(negedge clk);
    chk(carry_q == 1'b0, "R4 hold without step", carry_q, 0);

    // R5: clear beats step with carry-out 1
    @(negedge clk); step = 1'b1; carry_clr = 1'b1;
    @(negedge clk); step = 1'b0; carry_clr = 1'b0;
    chk(carry_q == 1'b0, "R5 clear over step", carry_q, 0);

    // R6: preset beats step with carry-out 0
    @(negedge clk); mem_digit = 4'd0; work_digit = 4'd0; step = 1'b1; carry_set = 1'b1;
    @(negedge clk); step = 1'b0; carry_set = 1'b0;
    chk(carry_q == 1'b1, "R6 set over step", carry_q, 1);

    // R5: clear beats preset
    @(negedge clk); carry_set = 1'b1; carry_clr = 1'b1;
    @(negedge clk); carry_set = 1'b0; carry_clr = 1'b0;
    chk(carry_q == 1'b0, "R5 clear over set", carry_q, 0);

    // R6: multi-digit subtraction, three digits
    for (int t = 0; t < 4; t++) begin
      int a, b, tot, res;
      a = (t == 0) ? 503 : (t == 1) ? 120 : (t == 2) ? 999 : 400;
      b = (t == 0) ? 278 : (t == 1) ? 345 : (t == 2) ? 999 : 401;
      tot = a + (999 - b) + 1;
      res = tot % 1000;
      preset(1'b1);
      for (int k = 0; k < 3; k++) begin
        int p;
        p = (k == 0) ? 1 : (k == 1) ? 10 : 100;
        @(negedge clk);
        mem_digit = 4'((a / p) % 10); work_digit = 4'((b / p) % 10);
        comp_sel = 1'b1; step = 1'b1;
        #1;
        chk(sum_digit == 4'((res / p) % 10), "R6 difference digit", sum_digit, (res / p) % 10);
      end
      @(negedge clk); step = 1'b0; comp_sel = 1'b0;
      chk(carry_q == (tot >= 1000), "R6 final no-borrow carry", carry_q, tot >= 1000);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule